// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block watches the single digital output of an infrared receiver module and describes what it sees as a stream of bytes. Each byte names a level (pulse or space) and how long that level lasted, counted in sample periods. The raw input is synchronised, optionally inverted, and sampled once per prescaler window of 64 base-clock cycles. A level change that lasts no longer than a programmable number of samples counts as noise and is folded back into the run it broke. A run longer than 128 samples is cut into full-length bytes.

A packet begins with the first pulse sample. It ends once the space level has lasted longer than a programmable idle threshold. The last space run is then emitted together with a one-cycle packet-end strobe, and the encoder stays silent until the next pulse sample. Software or a downstream FIFO consumes the byte stream. Both the global enable and the receive enable must be high for the encoder to run.

Top module: `ir_rle_encoder`

## Requirements
- R1: The (synchronised, possibly inverted) input is sampled once every 64 clock cycles while enabled; run lengths are counted in these sample periods and every output byte appears on the cycle after the sample edge that produced it.
- R2: An output byte holds the run level in bit 7 (1 = pulse, 0 = space) and the number of samples in the run minus one in bits 6:0, so code 0 means 1 sample and code 127 means 128 samples.
- R3: When `invert` is 1 the raw input is complemented before sampling, so a raw low is treated as a pulse.
- R4: A change of level lasting at most `noise_thr` samples is not emitted; its samples are added to the run it interrupted. A change lasting `noise_thr`+1 samples ends the previous run (which is then emitted) and starts a new run that already counts those samples. With `noise_thr` = 0 every change is accepted.
- R5: When a run reaches 128 samples a byte with length code 127 is emitted and counting of the same level restarts from zero.
- R6: When the count of consecutive space samples exceeds `idle_thr`, the pending space run is emitted with `pkt_end` high in the same cycle; `pkt_end` is never high without `out_valid`, and the final byte of a packet is always a space byte.
- R7: No byte is emitted from the end of a packet (or from enabling) until a pulse sample arrives; space samples in that interval are discarded and the first pulse sample starts a new run of length 1.
- R8: While either `glb_en` or `rx_en` is low, nothing is emitted and the prescaler and run state are cleared; after re-enabling, the first sample falls 64 cycles later and any run in progress before is lost. Reset leaves all outputs low.
- R9: When the sample that brings a space run to 128 samples is also the one that exceeds `idle_thr`, exactly one byte (space, code 127) is emitted with `pkt_end`; if the idle limit is crossed one sample after a 128-sample split, the split byte is followed by a final byte of code 0 with `pkt_end`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| invert | input | 1 | Complement the raw input before sampling |
| noise_thr | input | 6 | Longest level change, in samples, treated as noise |
| idle_thr | input | 8 | Space samples tolerated before the packet ends |
| ir_in | input | 1 | Raw receiver output, asynchronous |
| out_valid | output | 1 | Output byte valid for one cycle |
| out_data | output | 8 | Level in bit 7, length code in bits 6:0 |
| pkt_end | output | 1 | Marks the final byte of a packet |

## Verification
The two functions that can fall on the same sample are the 128-sample length split and idle termination of a space run. The bench sets the idle threshold to 127 and drives a space run long enough that both trigger on its 128th sample. It expects one space byte of code 127 with the packet-end flag, and no separate remainder byte. It then sets the threshold to 128 and expects the split byte first and then a code-0 final byte with the flag. This shows the idle check takes priority on the shared sample and that the remainder count restarts correctly after a split.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } trk_state_e;

  // Level seen by the encoder after optional inversion.
  function automatic logic f_level(input logic raw, input logic inv);
    return raw ^ inv;
  endfunction

  // Length code for a run of the given number of samples.
  function automatic int unsigned f_code(input int unsigned samples);
    return (samples == 0) ? 0 : samples - 1;
  endfunction

  // Run length after a same-level sample that also absorbs a glitch.
  function automatic int unsigned f_merge(input int unsigned run_len,
                                          input int unsigned glitch_len);
    return run_len + glitch_len + 1;
  endfunction

  // Saturating increment for the idle counter.
  function automatic int unsigned f_sat_inc(input int unsigned value,
                                            input int unsigned limit);
    return (value >= limit) ? limit : value + 1;
  endfunction

endpackage

// File: rtl/ir_rle_prescaler.sv
module ir_rle_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/ir_rle_sampler.sv
module ir_rle_sampler
  import ir_rle_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic invert,
  input  logic ir_in,
  output logic smp_valid,
  output logic smp_level
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ir_in;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ir_in};
      end
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_level <= 1'b0;
    end else begin
      smp_valid <= run && tick;
      if (run && tick) begin
        smp_level <= f_level(synced, invert);
      end
    end
  end

endmodule

// File: rtl/ir_rle_run_tracker.sv
module ir_rle_run_tracker
  import ir_rle_pkg::*;
#(
  parameter int LEN_W   = 7,
  parameter int NOISE_W = 6,
  parameter int IDLE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               smp_valid,
  input  logic               smp_level,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  output logic               out_valid,
  output logic [LEN_W:0]     out_data,
  output logic               pkt_end,
  output logic               waiting
);
  localparam int unsigned MAX_RUN = 1 << LEN_W;
  localparam int RW = LEN_W + 1;
  localparam int CW = NOISE_W + 1;
  localparam int IW = IDLE_W + 1;
  localparam int unsigned IDLE_SAT = (1 << IW) - 1;

  trk_state_e     st_q, st_n;
  logic           lvl_q, lvl_n;
  logic [RW-1:0]  run_q, run_n;
  logic [CW-1:0]  cand_q, cand_n;
  logic [IW-1:0]  idle_q, idle_n;

  logic             emit_v;
  logic             emit_lvl;
  logic [LEN_W-1:0] emit_code;
  logic             emit_end;

  // Named internal events
  logic ev_start, ev_merge, ev_split, ev_flip, ev_idle;

  int unsigned sum_len;
  int unsigned cand_inc;
  int unsigned idle_inc;

  always_comb begin
    st_n      = st_q;
    lvl_n     = lvl_q;
    run_n     = run_q;
    cand_n    = cand_q;
    idle_n    = idle_q;
    emit_v    = 1'b0;
    emit_lvl  = lvl_q;
    emit_code = '0;
    emit_end  = 1'b0;
    ev_start  = 1'b0;
    ev_merge  = 1'b0;
    ev_split  = 1'b0;
    ev_flip   = 1'b0;
    ev_idle   = 1'b0;

    sum_len  = f_merge(int'(run_q), int'(cand_q));
    cand_inc = int'(cand_q) + 1;
    idle_inc = smp_level ? 0 : f_sat_inc(int'(idle_q), IDLE_SAT);

    if (smp_valid) begin
      if (st_q == ST_WAIT) begin
        if (smp_level) begin
          ev_start = 1'b1;
          st_n     = ST_RUN;
          lvl_n    = 1'b1;
          run_n    = RW'(1);
          cand_n   = '0;
          idle_n   = '0;
        end
      end else begin
        idle_n = IW'(idle_inc);
        if (smp_level == lvl_q) begin
          cand_n   = '0;
          ev_merge = (cand_q != '0);
          if (!lvl_q && (cand_q == '0) && (idle_inc > int'(idle_thr))) begin
            ev_idle   = 1'b1;
            emit_v    = 1'b1;
            emit_lvl  = 1'b0;
            emit_code = LEN_W'(f_code(sum_len));
            emit_end  = 1'b1;
            st_n      = ST_WAIT;
            run_n     = '0;
            idle_n    = '0;
          end else if (sum_len >= MAX_RUN) begin
            ev_split  = 1'b1;
            emit_v    = 1'b1;
            emit_lvl  = lvl_q;
            emit_code = LEN_W'(MAX_RUN - 1);
            run_n     = RW'(sum_len - MAX_RUN);
          end else begin
            run_n = RW'(sum_len);
          end
        end else if (cand_inc > int'(noise_thr)) begin
          ev_flip = 1'b1;
          if (run_q != '0) begin
            emit_v    = 1'b1;
            emit_lvl  = lvl_q;
            emit_code = LEN_W'(f_code(int'(run_q)));
          end
          lvl_n  = smp_level;
          run_n  = RW'(cand_inc);
          cand_n = '0;
        end else begin
          cand_n = CW'(cand_inc);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      st_q      <= ST_WAIT;
      lvl_q     <= 1'b0;
      run_q     <= '0;
      cand_q    <= '0;
      idle_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      pkt_end   <= 1'b0;
    end else begin
      st_q      <= st_n;
      lvl_q     <= lvl_n;
      run_q     <= run_n;
      cand_q    <= cand_n;
      idle_q    <= idle_n;
      out_valid <= emit_v;
      out_data  <= emit_v ? {emit_lvl, emit_code} : '0;
      pkt_end   <= emit_end;
    end
  end

  assign waiting = (st_q == ST_WAIT);

endmodule

// File: rtl/ir_rle_encoder.sv
module ir_rle_encoder #(
  parameter int PRESCALE    = 64,
  parameter int LEN_W       = 7,
  parameter int NOISE_W     = 6,
  parameter int IDLE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic               rx_en,
  input  logic               invert,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  input  logic               ir_in,
  output logic               out_valid,
  output logic [LEN_W:0]     out_data,
  output logic               pkt_end
);
  logic run;
  logic tick;
  logic smp_valid;
  logic smp_level;
  logic waiting;
  logic out_is_pulse;

  assign run          = glb_en & rx_en;
  assign out_is_pulse = out_data[LEN_W];

  ir_rle_prescaler #(
    .DIV (PRESCALE)
  ) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  ir_rle_sampler #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .invert    (invert),
    .ir_in     (ir_in),
    .smp_valid (smp_valid),
    .smp_level (smp_level)
  );

  ir_rle_run_tracker #(
    .LEN_W   (LEN_W),
    .NOISE_W (NOISE_W),
    .IDLE_W  (IDLE_W)
  ) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .smp_valid (smp_valid),
    .smp_level (smp_level),
    .noise_thr (noise_thr),
    .idle_thr  (idle_thr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .pkt_end   (pkt_end),
    .waiting   (waiting)
  );

endmodule

// File: rtl/ir_rle_checker.sv
module ir_rle_checker (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic tick,
  input logic smp_valid,
  input logic waiting,
  input logic out_valid,
  input logic out_is_pulse,
  input logic pkt_end
);

  assert_one_tick_per_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_byte_follows_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(smp_valid));

  assert_end_has_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> out_valid);

  assert_end_byte_is_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> !out_is_pulse);

  assert_end_enters_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> waiting);

  assert_silent_while_waiting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(waiting) |-> !out_valid);

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (waiting && !out_valid && !smp_valid));

endmodule

bind ir_rle_encoder ir_rle_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (run),
  .tick         (tick),
  .smp_valid    (smp_valid),
  .waiting      (waiting),
  .out_valid    (out_valid),
  .out_is_pulse (out_is_pulse),
  .pkt_end      (pkt_end)
);

// File: tb/test_ir_rle_encoder.sv
`timescale 1ns/1ps
module test_ir_rle_encoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       glb_en, rx_en, invert, ir_in;
  logic [5:0] noise_thr;
  logic [7:0] idle_thr;
  logic       out_valid, pkt_end;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  ir_rle_encoder i_ir_rle_encoder (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rx_en(rx_en), .invert(invert),
    .noise_thr(noise_thr), .idle_thr(idle_thr), .ir_in(ir_in),
    .out_valid(out_valid), .out_data(out_data), .pkt_end(pkt_end)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] cap_d [0:255];
  logic       cap_e [0:255];
  int         n_cap = 0;
  logic [7:0] exp_d [0:15];
  logic       exp_e [0:15];
  int         n_exp = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1 && n_cap < 256) begin
      cap_d[n_cap] = out_data;
      cap_e[n_cap] = pkt_end;
      n_cap++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic e);
    exp_d[n_exp] = d;
    exp_e[n_exp] = e;
    n_exp++;
  endtask

  // Disable, program, re-enable on a falling edge; the caller drives at once.
  task automatic start(input int nthr, input int ithr, input logic inv);
    @(negedge clk);
    glb_en = 1'b0;
    rx_en  = 1'b0;
    ir_in  = inv;
    repeat (4) @(negedge clk);
    noise_thr = 6'(nthr);
    idle_thr  = 8'(ithr);
    invert    = inv;
    n_cap = 0;
    n_exp = 0;
    glb_en = 1'b1;
    rx_en  = 1'b1;
  endtask

  // Hold the input for n whole sample windows of 64 cycles each.
  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      ir_in = v;
      repeat (64) @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic compare(input string req);
    repeat (4) @(negedge clk);
    check(n_cap == n_exp, req, "byte count", n_cap, n_exp);
    for (int i = 0; i < n_exp && i < n_cap; i++) begin
      check(cap_d[i] == exp_d[i], req, $sformatf("byte %0d data", i), cap_d[i], exp_d[i]);
      check(cap_e[i] == exp_e[i], req, $sformatf("byte %0d end", i), cap_e[i], exp_e[i]);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; glb_en = 1'b1; rx_en = 1'b1; invert = 1'b0; ir_in = 1'b0;
    noise_thr = 6'd1; idle_thr = 8'd20;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "reset out_valid", out_valid, 0);
    check(pkt_end == 1'b0, "R8", "reset pkt_end", pkt_end, 0);
    check(out_data == 8'h00, "R8", "reset out_data", out_data, 0);
  endtask

  // R1 R2: sample-period lengths and byte format; R7: silence then restart
  task automatic t_basic;
    start(1, 20, 1'b0);
    drive(1, 5); drive(0, 3); drive(1, 2); drive(0, 25);
    drive(0, 10);
    drive(1, 3); drive(0, 22);
    push(8'h84, 0); push(8'h02, 0); push(8'h81, 0); push(8'h14, 1);
    push(8'h82, 0); push(8'h14, 1);
    compare("R1_R2_R7");
  endtask

  // R4: one-sample space glitch merged into a pulse run
  task automatic t_glitch;
    start(1, 20, 1'b0);
    drive(1, 6); drive(0, 1); drive(1, 4); drive(0, 22);
    push(8'h8A, 0); push(8'h14, 1);
    compare("R4");
  endtask

  // R4: programmed threshold 3, then threshold 0
  task automatic t_noise_prog;
    start(3, 20, 1'b0);
    drive(1, 5); drive(0, 3); drive(1, 2); drive(0, 22);
    push(8'h89, 0); push(8'h14, 1);
    compare("R4");
    start(0, 20, 1'b0);
    drive(1, 2); drive(0, 1); drive(1, 1); drive(0, 22);
    push(8'h81, 0); push(8'h00, 0); push(8'h80, 0); push(8'h14, 1);
    compare("R4");
  endtask

  // R5: a 130-sample pulse splits into 128 + 2
  task automatic t_split;
    start(1, 20, 1'b0);
    drive(1, 130); drive(0, 22);
    push(8'hFF, 0); push(8'h81, 0); push(8'h14, 1);
    compare("R5");
  endtask

  // R9: split and idle on the same sample, then idle one sample later
  task automatic t_idle_split;
    start(1, 127, 1'b0);
    drive(1, 3); drive(0, 130);
    push(8'h82, 0); push(8'h7F, 1);
    compare("R9");
    start(1, 128, 1'b0);
    drive(1, 3); drive(0, 131);
    push(8'h82, 0); push(8'h7F, 0); push(8'h00, 1);
    compare("R9");
  endtask

  // R3: inverted input; R7: leading space samples discarded
  task automatic t_invert;
    start(1, 20, 1'b1);
    drive(1, 3); drive(0, 4); drive(1, 22);
    push(8'h83, 0); push(8'h14, 1);
    compare("R3_R7");
  endtask

  // R8: dropping rx_en mid-run loses the run and restarts timing
  task automatic t_enable;
    start(1, 20, 1'b0);
    drive(1, 5);
    rx_en = 1'b0;
    ir_in = 1'b0;
    repeat (100) @(negedge clk);
    check(n_cap == 0, "R8", "bytes while disabled", n_cap, 0);
    rx_en = 1'b1;
    drive(0, 3); drive(1, 2); drive(0, 22);
    push(8'h81, 0); push(8'h14, 1);
    compare("R8");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_glitch();
    t_noise_prog();
    t_split();
    t_idle_split();
    t_invert();
    t_enable();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule